// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block watches a parameterised set of external lines (18 by default) and turns selected transitions on them into interrupt and event requests. Every line has two separate enable bits, one for rising and one for falling transitions. Either bit, both bits or neither may be set. A line also has an interrupt enable and an event enable. Detected interrupt requests are held in a pending register. Software reads that register and clears it by writing ones.

Each transition is first recorded by a capture flop that the line itself clocks. The recorded state then passes through a synchroniser into the clock domain. Because of this, a pulse that rises and falls between two clock edges is still recorded. The interrupt output is one level: the OR of every pending line that has its interrupt enabled. The event output carries one single-cycle pulse per line. A software trigger register injects a request on any line, as though the selected edge had occurred.

Top module: `edge_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all registers read zero, `irq_o` is low and `event_o` is zero.
- R2: A rising transition on a line with its rise enable bit and interrupt enable bit set sets that line's pending bit. The bit is set at the third rising clock edge after the transition.
- R3: A falling transition on a line with its fall enable bit and interrupt enable bit set sets that line's pending bit, with the same latency as R2.
- R4: A line with both enable bits set records either transition. A transition whose direction is not enabled leaves the pending bit unchanged.
- R5: A pulse whose rise and fall both fall between two consecutive clock edges is still recorded in the pending bit when either direction is enabled.
- R6: A trigger on a line whose interrupt enable is clear does not set its pending bit. `irq_o` is high exactly when some pending bit has its interrupt enable set, so clearing the enable lowers `irq_o` while the pending bit stays set.
- R7: A trigger on a line whose event enable is set gives a one-cycle high pulse on that bit of `event_o`. This is independent of the interrupt enable, and the pulse alone never sets a pending bit.
- R8: Writing to address 5 clears each pending bit written with 1. Bits written with 0 are unchanged. If a trigger and a clear reach the same bit at the same edge, the bit ends set.
- R9: Writing 1s to address 4 triggers those lines at that write's clock edge, exactly as a hardware edge would. Pending bits are set subject to the interrupt enable, and events are pulsed subject to the event enable. Address 4 always reads 0.
- R10: Register map, with line n at data bit n: 0 rise enable, 1 fall enable, 2 interrupt enable, 3 event enable, 4 software trigger, 5 pending. Addresses 6 and 7 and all data bits at or above the line count read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | External request lines, may be asynchronous |
| wr_en | input | 1 | Register write strobe, sampled at the rising clock edge |
| addr | input | 3 | Register address for read and write |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| irq_o | output | 1 | Combined interrupt request |
| event_o | output | NUM_LINES | Per-line single-cycle event pulses |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are synchronous to `clk` and stable around its rising edge. They also assume that each line makes at most one transition in each direction between two clock edges, since a second rise in the same interval cancels the first in the capture flop. The stimulus changes register inputs two time units after a clock edge and moves lines only between edges. Its narrowest pulse is a single rise and fall inside one period. A line stays quiet for several cycles before it moves again.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_RISE   = 3'd0,
      RA_FALL   = 3'd1,
      RA_IRQEN  = 3'd2,
      RA_EVTEN  = 3'd3,
      RA_SWTRIG = 3'd4,
      RA_PEND   = 3'd5
   } reg_addr_e;

endpackage

// File: rtl/edge_irq_capture.sv
module edge_irq_capture #(
   parameter int NUM_LINES     = 18,
   parameter int SYNC_STAGES   = 2,
   parameter bit ASYNC_CAPTURE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_i,
   output logic [NUM_LINES-1:0] rise_o,
   output logic [NUM_LINES-1:0] fall_o
);
   localparam int CHAIN = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_irq_capture: SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      if (ASYNC_CAPTURE) begin : g_async
         // toggle flops clocked by the line catch transitions of any width
         logic rtog, ftog;
         logic [CHAIN-1:0] rs, fs;

         always_ff @(posedge line_i[g] or negedge rst_n) begin
            if (!rst_n) rtog <= 1'b0;
            else        rtog <= ~rtog;
         end

         always_ff @(negedge line_i[g] or negedge rst_n) begin
            if (!rst_n) ftog <= 1'b0;
            else        ftog <= ~ftog;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rs <= '0;
               fs <= '0;
            end else begin
               rs <= {rs[CHAIN-2:0], rtog};
               fs <= {fs[CHAIN-2:0], ftog};
            end
         end

         assign rise_o[g] = rs[CHAIN-1] ^ rs[CHAIN-2];
         assign fall_o[g] = fs[CHAIN-1] ^ fs[CHAIN-2];
      end else begin : g_sampled
         logic [CHAIN-1:0] ls;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ls <= '0;
            else        ls <= {ls[CHAIN-2:0], line_i[g]};
         end

         assign rise_o[g] =  ls[CHAIN-2] & ~ls[CHAIN-1];
         assign fall_o[g] = ~ls[CHAIN-2] &  ls[CHAIN-1];
      end
   end

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
   import edge_irq_pkg::*;
#(
   parameter int NUM_LINES = 18,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_AW-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_LINES-1:0] rise_det,
   input  logic [NUM_LINES-1:0] fall_det,
   output logic [DATA_W-1:0]    rdata,
   output logic [NUM_LINES-1:0] pend_o,
   output logic [NUM_LINES-1:0] irq_en_o,
   output logic [NUM_LINES-1:0] event_o
);
   if (NUM_LINES > DATA_W || NUM_LINES < 1) begin : g_bad_width
      $error("edge_irq_regs: NUM_LINES must be 1..DATA_W");
   end

   logic [NUM_LINES-1:0] rise_en_q, fall_en_q, irq_en_q, evt_en_q, pend_q, event_q;
   logic [NUM_LINES-1:0] hw_trig, sw_trig, trig, clr, rd_line;
   logic [NUM_LINES-1:0] wline;

   assign wline = wdata[NUM_LINES-1:0];

   always_comb begin
      hw_trig = (rise_det & rise_en_q) | (fall_det & fall_en_q);
      sw_trig = (wr_en && addr == RA_SWTRIG) ? wline : '0;
      clr     = (wr_en && addr == RA_PEND)   ? wline : '0;
      trig    = hw_trig | sw_trig;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en_q <= '0;
         fall_en_q <= '0;
         irq_en_q  <= '0;
         evt_en_q  <= '0;
         pend_q    <= '0;
         event_q   <= '0;
      end else begin
         if (wr_en) begin
            case (addr)
               RA_RISE:  rise_en_q <= wline;
               RA_FALL:  fall_en_q <= wline;
               RA_IRQEN: irq_en_q  <= wline;
               RA_EVTEN: evt_en_q  <= wline;
               default: ;
            endcase
         end
         // a new trigger overrides a clear of the same bit
         pend_q  <= (pend_q & ~clr) | (trig & irq_en_q);
         event_q <= trig & evt_en_q;
      end
   end

   always_comb begin
      case (addr)
         RA_RISE:  rd_line = rise_en_q;
         RA_FALL:  rd_line = fall_en_q;
         RA_IRQEN: rd_line = irq_en_q;
         RA_EVTEN: rd_line = evt_en_q;
         RA_PEND:  rd_line = pend_q;
         default:  rd_line = '0;
      endcase
      rdata = '0;
      rdata[NUM_LINES-1:0] = rd_line;
   end

   assign pend_o   = pend_q;
   assign irq_en_o = irq_en_q;
   assign event_o  = event_q;

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int NUM_LINES     = 18,
   parameter int DATA_W        = 32,
   parameter int SYNC_STAGES   = 2,
   parameter bit ASYNC_CAPTURE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_i,
   input  logic                 wr_en,
   input  logic [2:0]           addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic                 irq_o,
   output logic [NUM_LINES-1:0] event_o
);
   logic [NUM_LINES-1:0] rise_w, fall_w, pend_w, irq_en_w;

   edge_irq_capture #(
      .NUM_LINES    (NUM_LINES),
      .SYNC_STAGES  (SYNC_STAGES),
      .ASYNC_CAPTURE(ASYNC_CAPTURE)
   ) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(line_i),
      .rise_o(rise_w),
      .fall_o(fall_w)
   );

   edge_irq_regs #(
      .NUM_LINES(NUM_LINES),
      .DATA_W   (DATA_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rise_det(rise_w),
      .fall_det(fall_w),
      .rdata   (rdata),
      .pend_o  (pend_w),
      .irq_en_o(irq_en_w),
      .event_o (event_o)
   );

   assign irq_o = |(pend_w & irq_en_w);

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk
   import edge_irq_pkg::*;
#(
   parameter int NUM_LINES = 18,
   parameter int DATA_W    = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [2:0]           addr,
   input logic [DATA_W-1:0]    wdata,
   input logic [DATA_W-1:0]    rdata,
   input logic                 irq_o,
   input logic [NUM_LINES-1:0] event_o,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] irq_en
);
   logic [NUM_LINES-1:0] wr_clear;
   assign wr_clear = (wr_en && addr == RA_PEND) ? wdata[NUM_LINES-1:0] : '0;

   // R1: reset leaves no pending bit, event or interrupt
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (pend == '0 && event_o == '0 && !irq_o));

   // R6: a pending bit can only appear while its interrupt enable was set
   a_r6_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~$past(irq_en)) == '0);

   // R8: a pending bit drops only after a write of 1 to it
   a_r8_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (~pend & $past(pend) & ~$past(wr_clear)) == '0);

   // R9: the software trigger register reads as zero
   a_r9_swtrig_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == RA_SWTRIG) |-> (rdata == '0));

   // R10: unmapped addresses read as zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr > RA_PEND) |-> (rdata == '0));

endmodule

bind edge_irq_ctrl edge_irq_chk #(
   .NUM_LINES(NUM_LINES),
   .DATA_W   (DATA_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .irq_o  (irq_o),
   .event_o(event_o),
   .pend   (pend_w),
   .irq_en (irq_en_w)
);

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 18;
   localparam int DW = 32;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  line  = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    addr  = '0;
   logic [DW-1:0] wdata = '0;
   wire  [DW-1:0] rdata;
   wire           irq;
   wire  [N-1:0]  evt;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .line_i(line), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_o(irq), .event_o(evt)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [N-1:0] m_rise = '0, m_fall = '0, m_irqen = '0, m_evten = '0;
   logic [N-1:0] m_pend = '0, m_evt = '0;
   logic [N-1:0] rf_flag = '0, ff_flag = '0;
   logic [2*N-1:0] dq[$];
   int evcnt[N];

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mread(logic [2:0] a);
      logic [N-1:0] v;
      case (a)
         3'd0: v = m_rise;
         3'd1: v = m_fall;
         3'd2: v = m_irqen;
         3'd3: v = m_evten;
         3'd5: v = m_pend;
         default: v = '0;
      endcase
      return {{(DW-N){1'b0}}, v};
   endfunction

   // model: a transition seen between edges k-1 and k acts at edge k+2
   always @(posedge clk) begin : model
      logic [N-1:0] hw, sw, clr, trig;
      logic [2*N-1:0] e;
      if (!rst_n) begin
         m_rise = '0; m_fall = '0; m_irqen = '0; m_evten = '0;
         m_pend = '0; m_evt = '0;
         rf_flag = '0; ff_flag = '0;
         dq.delete();
      end else begin
         dq.push_back({ff_flag, rf_flag});
         rf_flag = '0;
         ff_flag = '0;
         hw = '0;
         if (dq.size() == 3) begin
            e  = dq.pop_front();
            hw = (e[N-1:0] & m_rise) | (e[2*N-1:N] & m_fall);
         end
         sw   = (wr_en && addr == 3'd4) ? wdata[N-1:0] : '0;
         clr  = (wr_en && addr == 3'd5) ? wdata[N-1:0] : '0;
         trig = hw | sw;
         m_pend = (m_pend & ~clr) | (trig & m_irqen);
         m_evt  = trig & m_evten;
         if (wr_en) begin
            case (addr)
               3'd0: m_rise  = wdata[N-1:0];
               3'd1: m_fall  = wdata[N-1:0];
               3'd2: m_irqen = wdata[N-1:0];
               3'd3: m_evten = wdata[N-1:0];
               default: ;
            endcase
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      chk("R6 irq_o vs model", {31'd0, irq}, {31'd0, |(m_pend & m_irqen)});
      chk("R7 event_o vs model", {{(DW-N){1'b0}}, evt}, {{(DW-N){1'b0}}, m_evt});
      chk("R10 rdata vs model", rdata, mread(addr));
      for (int i = 0; i < N; i++) if (evt[i]) evcnt[i]++;
   end

   task automatic set_line(int i, logic v);
      @(posedge clk); #2;
      if (v && !line[i]) rf_flag[i] = 1'b1;
      if (!v && line[i]) ff_flag[i] = 1'b1;
      line[i] = v;
   endtask

   task automatic short_pulse(int i);
      @(posedge clk); #2;
      line[i] = 1'b1; rf_flag[i] = 1'b1;
      #3;
      line[i] = 1'b0; ff_flag[i] = 1'b1;
   endtask

   task automatic wr(logic [2:0] a, logic [DW-1:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #2;
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd_chk(string tag, logic [2:0] a, logic [DW-1:0] exp);
      @(posedge clk); #2;
      addr = a;
      @(negedge clk);
      chk(tag, rdata, exp);
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int e0, e4;
      for (int i = 0; i < N; i++) evcnt[i] = 0;
      idle(3);
      @(negedge clk);
      chk("R1 irq in reset", {31'd0, irq}, 32'd0);
      chk("R1 event in reset", {{(DW-N){1'b0}}, evt}, 32'd0);
      @(posedge clk); #2; rst_n = 1'b1;
      for (int a = 0; a < 8; a++) rd_chk("R1 register after reset", 3'(a), 32'd0);

      wr(3'd0, 32'h7D);
      wr(3'd1, 32'h2E);
      wr(3'd2, 32'h3FFEF);
      wr(3'd3, 32'h11);
      rd_chk("R10 rise enable readback", 3'd0, 32'h7D);
      rd_chk("R10 event enable readback", 3'd3, 32'h11);

      set_line(0, 1'b1); idle(4);
      rd_chk("R2 rising edge pends", 3'd5, 32'h1);
      chk("R2 irq after rise", {31'd0, irq}, 32'd1);

      set_line(1, 1'b1); idle(4);
      rd_chk("R4 rise ignored on fall-only line", 3'd5, 32'h1);
      set_line(1, 1'b0); idle(4);
      rd_chk("R3 falling edge pends", 3'd5, 32'h3);

      set_line(2, 1'b1); idle(4);
      rd_chk("R4 both: rise", 3'd5, 32'h7);
      wr(3'd5, 32'h4);
      rd_chk("R8 clear one bit", 3'd5, 32'h3);
      set_line(2, 1'b0); idle(4);
      rd_chk("R4 both: fall", 3'd5, 32'h7);

      set_line(6, 1'b1); idle(4);
      rd_chk("R2 line 6 rise", 3'd5, 32'h47);
      wr(3'd5, 32'h40);
      set_line(6, 1'b0); idle(4);
      rd_chk("R4 fall ignored on rise-only line", 3'd5, 32'h7);

      e4 = evcnt[4];
      set_line(4, 1'b1); idle(4);
      rd_chk("R6 masked line not pended", 3'd5, 32'h7);
      chk("R7 single event pulse", 32'(evcnt[4] - e4), 32'd1);

      short_pulse(5); idle(4);
      rd_chk("R5 sub-cycle pulse captured", 3'd5, 32'h27);

      wr(3'd5, 32'h0);
      rd_chk("R8 write zero no effect", 3'd5, 32'h27);
      wr(3'd5, 32'hFFFF_FFFF);
      rd_chk("R8 clear all", 3'd5, 32'h0);
      chk("R6 irq low when nothing pends", {31'd0, irq}, 32'd0);

      set_line(3, 1'b1);
      @(posedge clk);
      wr(3'd5, 32'h8);
      rd_chk("R8 set wins over clear", 3'd5, 32'h8);
      wr(3'd5, 32'hFFFF_FFFF);

      e0 = evcnt[0]; e4 = evcnt[4];
      wr(3'd4, 32'h11);
      rd_chk("R9 software trigger pends", 3'd5, 32'h1);
      chk("R9 sw event line 0", 32'(evcnt[0] - e0), 32'd1);
      chk("R9 sw event line 4", 32'(evcnt[4] - e4), 32'd1);
      rd_chk("R9 trigger reads zero", 3'd4, 32'h0);

      wr(3'd2, 32'h0);
      @(negedge clk);
      chk("R6 irq drops with enable", {31'd0, irq}, 32'd0);
      rd_chk("R6 pending kept", 3'd5, 32'h1);

      rd_chk("R10 address 6 zero", 3'd6, 32'h0);
      rd_chk("R10 address 7 zero", 3'd7, 32'h0);
      wr(3'd0, 32'hFFFF_FFFF);
      rd_chk("R10 upper bits zero", 3'd0, 32'h3FFFF);

      idle(3);
      summary();
      $finish;
   end

endmodule